// File: doc/BRIEF.md
# Interrupt Flag and Enable Register Pair

This block gathers interrupt events for a peripheral interface device on a byte-wide register bus. Seven event sources each raise their own flag with a single-cycle set pulse. The sources are timer 1, timer 2, the shift register and four spare inputs. The CPU sees two byte registers: a flag register that shows which events are pending, and an enable register that masks them. A registered, active-high interrupt request goes out to the processor.

Bit 7 of each register does not hold a source. On a flag read it reports whether any pending source is also enabled. On an enable read it always reads as one. On an enable write it chooses between setting and clearing the enables picked by bits 6..0.

A flag write clears the flags whose written bit is one. This lets software acknowledge single events without disturbing the others. Reads have no side effects.

Top module: `irq_flag_enable`

## Requirements
- R1: `irq_o` is registered. After each clock edge it is one exactly when, before that edge, some flag bit and its enable bit were both one.
- R2: With `bus_sel`=0, `bus_rdata` bits 6..0 are the flags. Bit 7 is one exactly when (flags AND enables) is non-zero.
- R3: A write (`bus_cs`=1, `bus_we`=1) with `bus_sel`=0 clears each flag whose `bus_wdata` bit is one. Flags whose written bit is zero keep their value.
- R4: An enable write (`bus_sel`=1) with `bus_wdata[7]`=1 ORs `bus_wdata[6:0]` into the enables.
- R5: An enable write with `bus_wdata[7]`=0 clears each enable whose `bus_wdata` bit is one and leaves the other enables unchanged.
- R6: With `bus_sel`=1, `bus_rdata` is {1, enables}. Bit 7 always reads as one.
- R7: A clock edge with `rst_n` low clears the flags, the enables and `irq_o`.
- R8: Set pulses land on these flag bits: `t1_evt` on bit 6, `t2_evt` on bit 5, `sr_evt` on bit 2, `spare_evt[0]` on bit 0, `spare_evt[1]` on bit 1, `spare_evt[2]` on bit 3 and `spare_evt[3]` on bit 4.
- R9: When a set pulse and a CPU clear hit the same flag in the same cycle, the flag ends up set.
- R10: Cycles without a write have no effect on the enables, and leave the flags changed only by set pulses. Reads, and writes with `bus_cs` low, count as cycles without a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_cs | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_sel | input | 1 | 0 = flag register, 1 = enable register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| t1_evt | input | 1 | Timer 1 set pulse |
| t2_evt | input | 1 | Timer 2 set pulse |
| sr_evt | input | 1 | Shift register set pulse |
| spare_evt | input | 4 | Spare source set pulses |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The embedded properties check on every cycle:
- the one-cycle lag of `irq_o` behind the masked flags;
- the clearing by flag writes;
- that a pulsed flag is always set;
- the two enable write modes;
- that idle cycles hold state.

Only the bench's scenarios show:
- the bit position of each source;
- the bit 7 encoding on both reads;
- that a set wins over a clear in the same cycle;
- the return to zero after a reset in mid-run.

The bench shows these by comparing the read data with a model of its own.

// File: rtl/ifer_pkg.sv
// Shared constants and types for the interrupt flag/enable pair.
// Assumes a byte-wide bus whose top bit is a control/summary bit.
package ifer_pkg;
    localparam int BUS_W   = 8;
    localparam int FLAG_N  = BUS_W - 1;
    localparam int SPARE_N = 4;
    localparam int T1_POS  = 6;
    localparam int T2_POS  = 5;
    localparam int SR_POS  = 2;

    typedef enum logic {
        REG_FLAG   = 1'b0,
        REG_ENABLE = 1'b1
    } reg_sel_e;

    // Flag bit used by spare source idx: bits 0,1 then 3,4 (bit 2 is the shift register).
    function automatic int spare_pos(int idx);
        return (idx < SR_POS) ? idx : idx + 1;
    endfunction
endpackage

// File: rtl/ifer_flag_bank.sv
// Pending-event flags. Set pulses OR in, CPU writes clear bits written as one.
// Assumes set_vec holds single-cycle pulses. A set wins over a clear in the same cycle.
module ifer_flag_bank #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic         clr_wr,
    input  logic [N-1:0] clr_mask,
    output logic [N-1:0] flags
);
    logic [N-1:0] flags_q;
    logic [N-1:0] keep_mask;

    // Bits that survive this cycle's CPU clear.
    always_comb keep_mask = clr_wr ? ~clr_mask : '1;

    // Flag storage: clear first, then the set pulses take priority.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (flags_q & keep_mask) | set_vec;
    end

    assign flags = flags_q;

    // R3
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> ((flags_q & $past(clr_mask & ~set_vec)) == '0));
    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((flags_q & $past(set_vec)) == $past(set_vec)));
    // R10
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_wr && set_vec == '0) |=> $stable(flags_q));
endmodule

// File: rtl/ifer_enable_bank.sv
// Enable mask. The top write bit selects set mode (1) or clear mode (0) for the low bits.
// Assumes wr is a single-cycle write strobe with wdata valid alongside it.
module ifer_enable_bank #(
    parameter int N = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [N:0] wdata,
    output logic [N-1:0] en
);
    localparam int MODE_BIT = N;
    logic [N-1:0] en_q;
    logic [N-1:0] en_next;

    // Next mask from the write mode.
    always_comb begin
        if (!wr)                 en_next = en_q;
        else if (wdata[MODE_BIT]) en_next = en_q | wdata[N-1:0];
        else                     en_next = en_q & ~wdata[N-1:0];
    end

    // Enable storage.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_next;
    end

    assign en = en_q;

    // R4
    en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && wdata[MODE_BIT]) |=> ((en_q & $past(wdata[N-1:0])) == $past(wdata[N-1:0])));
    // R5
    en_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !wdata[MODE_BIT]) |=> ((en_q & $past(wdata[N-1:0])) == '0));
    // R10
    en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(en_q));
endmodule

// File: rtl/ifer_irq_view.sv
// Read-data view of the pair plus the registered request output.
// Assumes flags and en are register outputs. Reads have no side effects.
module ifer_irq_view #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] flags,
    input  logic [N-1:0] en,
    input  logic         sel,
    output logic [N:0]   rdata,
    output logic         irq
);
    logic any_active;
    logic irq_q;

    // Summary of enabled pending sources.
    always_comb any_active = |(flags & en);

    // Read multiplexer with the bit 7 encodings.
    always_comb rdata = sel ? {1'b1, en} : {any_active, flags};

    // Registered request.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= any_active;
    end

    assign irq = irq_q;

    // R1
    irq_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_q == $past(|(flags & en))));
endmodule

// File: rtl/irq_flag_enable.sv
// Top: interrupt flag and enable register pair on a byte-wide register bus.
// Maps the event pulses onto flag bits, decodes bus writes and drives the request output.
// Assumes a synchronous active-low reset and single-cycle event pulses.
module irq_flag_enable
    import ifer_pkg::*;
#(
    parameter int DATA_W = ifer_pkg::BUS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_cs,
    input  logic              bus_we,
    input  logic              bus_sel,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              t1_evt,
    input  logic              t2_evt,
    input  logic              sr_evt,
    input  logic [SPARE_N-1:0] spare_evt,
    output logic              irq_o
);
    localparam int N = DATA_W - 1;

    logic [N-1:0] set_vec;
    logic [N-1:0] flags;
    logic [N-1:0] en;
    logic         wr_stb, wr_flag, wr_en;

    // Source-to-bit mapping of the set pulses.
    always_comb begin
        set_vec         = '0;
        set_vec[T1_POS] = t1_evt;
        set_vec[T2_POS] = t2_evt;
        set_vec[SR_POS] = sr_evt;
        for (int i = 0; i < SPARE_N; i++) set_vec[spare_pos(i)] = spare_evt[i];
    end

    // Write strobe decode.
    always_comb begin
        wr_stb  = bus_cs & bus_we;
        wr_flag = wr_stb & (bus_sel == REG_FLAG);
        wr_en   = wr_stb & (bus_sel == REG_ENABLE);
    end

    ifer_flag_bank #(.N(N)) u_flags (
        .clk(clk), .rst_n(rst_n), .set_vec(set_vec),
        .clr_wr(wr_flag), .clr_mask(bus_wdata[N-1:0]), .flags(flags)
    );

    ifer_enable_bank #(.N(N)) u_en (
        .clk(clk), .rst_n(rst_n), .wr(wr_en), .wdata(bus_wdata), .en(en)
    );

    ifer_irq_view #(.N(N)) u_view (
        .clk(clk), .rst_n(rst_n), .flags(flags), .en(en),
        .sel(bus_sel), .rdata(bus_rdata), .irq(irq_o)
    );

    // R7
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (flags == '0 && en == '0 && !irq_o));
endmodule

// File: tb/test_irq_flag_enable.sv
`timescale 1ns/1ps
module test_irq_flag_enable;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_cs = 1'b0, bus_we = 1'b0, bus_sel = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       t1_evt = 1'b0, t2_evt = 1'b0, sr_evt = 1'b0;
    logic [3:0] spare_evt = 4'h0;
    logic       irq_o;

    int total = 0;
    int bad   = 0;
    logic [6:0] mf = '0;
    logic [6:0] me = '0;
    logic       mirq = 1'b0;

    always #5 clk = ~clk;

    irq_flag_enable i_irq_flag_enable (
        .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_we(bus_we), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .t1_evt(t1_evt), .t2_evt(t2_evt),
        .sr_evt(sr_evt), .spare_evt(spare_evt), .irq_o(irq_o)
    );

    // R8 bit map: t1->6, t2->5, spare3->4, spare2->3, sr->2, spare1->1, spare0->0
    function automatic logic [6:0] map_src(logic a1, logic a2, logic s, logic [3:0] sp);
        return {a1, a2, sp[3], sp[2], s, sp[1], sp[0]};
    endfunction

    function automatic logic [7:0] exp_rd(logic sel);
        return sel ? {1'b1, me} : {|(mf & me), mf};
    endfunction

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock cycle: drive at negedge, update the model, check after the edge.
    task automatic cycle(string tag, logic cs, logic we, logic sel, logic [7:0] wd,
                         logic a1, logic a2, logic s, logic [3:0] sp);
        logic [6:0] nf, ne, sv;
        @(negedge clk);
        bus_cs = cs; bus_we = we; bus_sel = sel; bus_wdata = wd;
        t1_evt = a1; t2_evt = a2; sr_evt = s; spare_evt = sp;
        sv = map_src(a1, a2, s, sp);
        nf = mf; ne = me;
        if (cs && we && !sel) nf = nf & ~wd[6:0];
        nf = nf | sv;
        if (cs && we && sel) ne = wd[7] ? (me | wd[6:0]) : (me & ~wd[6:0]);
        @(posedge clk);
        #2;
        mirq = |(mf & me);
        mf = nf; me = ne;
        chk("R1 irq", {7'd0, irq_o}, {7'd0, mirq});
        chk(tag, bus_rdata, exp_rd(sel));
    endtask

    task automatic rd(string tag, logic sel);
        cycle(tag, 1'b1, 1'b0, sel, 8'h00, 1'b0, 1'b0, 1'b0, 4'h0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        bus_cs = 1'b0; t1_evt = 1'b0; t2_evt = 1'b0; sr_evt = 1'b0; spare_evt = 4'h0;
        @(posedge clk); @(posedge clk);
        #2;
        mf = '0; me = '0; mirq = 1'b0;
        bus_sel = 1'b0;
        #1;
        chk("R7 flags", bus_rdata, 8'h00);
        chk("R7 irq", {7'd0, irq_o}, 8'h00);
        bus_sel = 1'b1;
        #1;
        chk("R7 enables", bus_rdata, 8'h80);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #1000000;
        total++; bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        do_reset();

        // R8: each source on its own bit, then R3 clear-all
        cycle("R8 t1", 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 4'h0);
        chk("R8 t1 bit6", {1'b0, mf}, 8'h40);
        cycle("R3 clear", 1'b1, 1'b1, 1'b0, 8'h7f, 1'b0, 1'b0, 1'b0, 4'h0);
        cycle("R8 t2", 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 4'h0);
        cycle("R8 sr", 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 4'h0);
        cycle("R3 partial", 1'b1, 1'b1, 1'b0, 8'h20, 1'b0, 1'b0, 1'b0, 4'h0);
        for (int i = 0; i < 4; i++) begin
            cycle("R8 spare", 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 4'(1 << i));
        end
        chk("R8 bits", {1'b0, mf}, 8'h1f);
        cycle("R3 clear2", 1'b1, 1'b1, 1'b0, 8'hff, 1'b0, 1'b0, 1'b0, 4'h0);

        // R4/R5/R6 enable modes
        cycle("R4 set", 1'b1, 1'b1, 1'b1, 8'hc5, 1'b0, 1'b0, 1'b0, 4'h0);
        cycle("R4 set more", 1'b1, 1'b1, 1'b1, 8'h82, 1'b0, 1'b0, 1'b0, 4'h0);
        cycle("R5 clear", 1'b1, 1'b1, 1'b1, 8'h04, 1'b0, 1'b0, 1'b0, 4'h0);
        rd("R6 read", 1'b1);

        // R1/R2: enabled source raises summary and request one cycle later
        cycle("R2 pulse", 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 4'h0);
        rd("R2 summary", 1'b0);
        rd("R1 hold", 1'b0);
        cycle("R2 disabled src", 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 4'h0);

        // R9: set and clear of timer 2 in the same cycle
        cycle("R9 race", 1'b1, 1'b1, 1'b0, 8'h20, 1'b0, 1'b1, 1'b0, 4'h0);
        chk("R9 t2 kept", {7'd0, mf[5]}, 8'h01);

        // R10: reads and deselected writes change nothing
        cycle("R10 read", 1'b1, 1'b0, 1'b0, 8'hff, 1'b0, 1'b0, 1'b0, 4'h0);
        cycle("R10 nocs", 1'b0, 1'b1, 1'b1, 8'h7f, 1'b0, 1'b0, 1'b0, 4'h0);
        rd("R10 enables", 1'b1);

        // R7 reset in mid-run
        do_reset();

        // Random traffic
        for (int n = 0; n < 3000; n++) begin
            logic cs, we, sel;
            logic [7:0] wd;
            logic [3:0] sp;
            cs  = ($urandom % 3) == 0;
            we  = $urandom % 2;
            sel = $urandom % 2;
            wd  = 8'($urandom);
            sp  = 4'($urandom) & 4'($urandom) & 4'($urandom);
            cycle(sel ? "R6 R10 random" : "R2 R10 random", cs, we, sel, wd,
                  ($urandom % 8) == 0, ($urandom % 8) == 0, ($urandom % 8) == 0, sp);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule